// File: doc/BRIEF.md
# Periodic Schedule Frame Entry Fetcher

This block starts the periodic schedule of a USB host controller once per micro-frame. It keeps a running micro-frame index. On each micro-frame tick, while the schedule is enabled, it builds the address of the current frame list slot and reads that 32-bit link pointer over a single-word read port. The read port has a valid/ready request channel and a response channel that carries only a valid. The block then decodes the word and offers the result on a valid/ready output. The result is either an empty-frame marker or the 32-byte-aligned address and kind of the first periodic object for the frame.

The frame list sits on a 4 KiB boundary. Each list slot covers eight consecutive micro-frames. The list holds 1024, 512 or 256 slots, and a 2-bit length field picks the length. Only one fetch is in flight at a time. A fetch stays busy from the tick that starts it until its result is accepted or dropped. A tick that arrives while the block is busy is not queued and sets a sticky overrun flag.

Back-pressure rules are as follows. `rd_req_valid` stays high with a constant `rd_req_addr` until `rd_req_ready` is high at a clock edge. The response is taken on the first edge with `rd_rsp_valid` high after the request was accepted. `item_valid` stays high with constant item fields until `item_ready` is high at a clock edge, unless the schedule is disabled first.

Top module: `periodic_list_fetcher`

## Requirements
- R1: After reset `frame_index` is 0, and `rd_req_valid`, `item_valid` and `overrun` are all low.
- R2: `frame_index` increases by one (wrapping at 2^FIDX_W) on every clock edge where `uframe_tick` is high, whether or not the schedule is enabled.
- R3: The read address is `{list_base[31:12], 12'h000}` plus 4 × slot. Bits 11:0 of `list_base` are ignored. The slot is `frame_index >> 3` masked to the list length, using the index value before that tick's increment.
- R4: `list_len` selects the list length: 00 gives 1024 slots, 01 gives 512, 10 gives 256, and 11 gives 1024.
- R5: A request is presented on the cycle after the starting tick. It is held with a stable address until accepted. At most one read is outstanding, and the read port and the item output are never valid together.
- R6: If bit 0 of the fetched word is 1, the item reports `item_empty`=1 with `item_addr`=0, `item_kind`=00 and `item_unsupported`=0.
- R7: Otherwise `item_kind` is bits 2:1 of the word (00 isochronous descriptor, 01 queue head, 10 split isochronous descriptor, 11 frame span node). `item_addr` is the word with bits 4:0 cleared. `item_unsupported` is 1 only for kind 11.
- R8: `item_valid` rises on the cycle after the response edge. It holds until `item_ready` is sampled high, then drops on the next cycle.
- R9: A tick while a fetch is busy sets `overrun`, which stays set until reset. Such a tick starts no extra read.
- R10: While `sched_en` is low no read starts and `item_valid` is low. A result that is pending or arrives while the schedule is disabled is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sched_en | input | 1 | Periodic schedule enable |
| list_base | input | 32 | Frame list base address (low 12 bits ignored) |
| list_len | input | 2 | List length select |
| uframe_tick | input | 1 | Micro-frame start pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read address of the frame list slot |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Fetched link pointer |
| item_valid | output | 1 | Decoded result valid |
| item_ready | input | 1 | Consumer takes the result |
| item_empty | output | 1 | Frame has no periodic work |
| item_kind | output | 2 | Referenced object kind |
| item_addr | output | 32 | 32-byte-aligned object address |
| item_unsupported | output | 1 | Object kind is the frame span node |
| overrun | output | 1 | Sticky tick-while-busy flag |
| frame_index | output | 14 | Running micro-frame index |

## Verification
The bench runs the index far enough to wrap the slot number for each of the three list lengths. A design that masked the slot wrongly, or used the index after its own increment, would fetch from the wrong slot at the wrap point. It writes nonzero low base bits and fetched words with bits 0, 3 and 4 set. A block that leaked base bits into the address, failed to clear the object address on an empty frame, or kept bits 4:3 would show it in the compared fields. It stalls both handshakes, disables the schedule in the middle of a fetch, and sends ticks closer together than a fetch lasts. A design that dropped a held request, double-issued a read, or let overrun clear or set while idle would diverge from the per-cycle model.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned BASE_LSB  = 12;  // 4 KiB list alignment
  localparam int unsigned OBJ_LSB   = 5;   // 32-byte object alignment
  localparam int unsigned SUB_SHIFT = 3;   // 8 micro-frames per slot

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } fetch_st_e;

  typedef enum logic [1:0] {
    KIND_ISO  = 2'b00,
    KIND_QH   = 2'b01,
    KIND_SISO = 2'b10,
    KIND_FSPN = 2'b11
  } obj_kind_e;

  typedef struct packed {
    logic          empty;
    obj_kind_e     kind;
    logic [AW-1:0] addr;
    logic          unsupported;
  } link_info_t;
endpackage

// File: rtl/pfl_frame_counter.sv
module pfl_frame_counter #(
  parameter int unsigned FIDX_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [FIDX_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/pfl_slot_addr.sv
module pfl_slot_addr
  import pfl_pkg::*;
#(
  parameter int unsigned LIST_AW  = 10,
  parameter bit          PROG_LEN = 1'b1
) (
  input  logic [AW-1:BASE_LSB] base_hi,
  input  logic [1:0]           list_len,
  input  logic [LIST_AW-1:0]   slot_raw,
  output logic [AW-1:0]        addr
);
  localparam int unsigned PAD_W = BASE_LSB - LIST_AW - 2;

  logic [LIST_AW-1:0] slot_mask;
  logic [LIST_AW-1:0] slot;

  generate
    if (PROG_LEN) begin : g_prog
      always_comb begin
        case (list_len)
          2'b01:   slot_mask = {LIST_AW{1'b1}} >> 1;
          2'b10:   slot_mask = {LIST_AW{1'b1}} >> 2;
          default: slot_mask = {LIST_AW{1'b1}};
        endcase
      end
    end else begin : g_fixed
      logic unused_len;
      assign unused_len = ^list_len;
      assign slot_mask  = {LIST_AW{1'b1}};
    end
  endgenerate

  assign slot = slot_raw & slot_mask;
  assign addr = {base_hi, {PAD_W{1'b0}}, slot, 2'b00};
endmodule

// File: rtl/pfl_ptr_decode.sv
module pfl_ptr_decode
  import pfl_pkg::*;
(
  input  logic [AW-1:0] ptr,
  output link_info_t    info
);
  logic unused_ptr;
  assign unused_ptr = ^ptr[OBJ_LSB-1:3];

  always_comb begin
    info.empty = ptr[0];
    if (ptr[0]) begin
      info.kind        = KIND_ISO;
      info.addr        = '0;
      info.unsupported = 1'b0;
    end else begin
      info.kind        = obj_kind_e'(ptr[2:1]);
      info.addr        = {ptr[AW-1:OBJ_LSB], {OBJ_LSB{1'b0}}};
      info.unsupported = (ptr[2:1] == KIND_FSPN);
    end
  end
endmodule

// File: rtl/periodic_list_fetcher.sv
module periodic_list_fetcher
  import pfl_pkg::*;
#(
  parameter int unsigned FIDX_W   = 14,
  parameter int unsigned LIST_AW  = 10,
  parameter bit          PROG_LEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_en,
  input  logic [31:0]       list_base,
  input  logic [1:0]        list_len,
  input  logic              uframe_tick,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              item_valid,
  input  logic              item_ready,
  output logic              item_empty,
  output logic [1:0]        item_kind,
  output logic [31:0]       item_addr,
  output logic              item_unsupported,
  output logic              overrun,
  output logic [FIDX_W-1:0] frame_index
);
  fetch_st_e     state;
  logic [AW-1:0] req_addr_q;
  logic [AW-1:0] next_addr;
  link_info_t    info_q;
  link_info_t    info_d;
  logic          ovr_q;
  logic          unused_base_lo;

  assign unused_base_lo = ^list_base[BASE_LSB-1:0];

  pfl_frame_counter #(.FIDX_W(FIDX_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (uframe_tick),
    .count (frame_index)
  );

  pfl_slot_addr #(.LIST_AW(LIST_AW), .PROG_LEN(PROG_LEN)) u_addr (
    .base_hi  (list_base[AW-1:BASE_LSB]),
    .list_len (list_len),
    .slot_raw (frame_index[SUB_SHIFT +: LIST_AW]),
    .addr     (next_addr)
  );

  pfl_ptr_decode u_dec (
    .ptr  (rd_rsp_data),
    .info (info_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      req_addr_q <= '0;
      info_q     <= '0;
      ovr_q      <= 1'b0;
    end else begin
      if (uframe_tick && state != ST_IDLE) ovr_q <= 1'b1;
      case (state)
        ST_IDLE: if (uframe_tick && sched_en) begin
          req_addr_q <= next_addr;
          state      <= ST_REQ;
        end
        ST_REQ:  if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          info_q <= info_d;
          state  <= sched_en ? ST_OUT : ST_IDLE;
        end
        ST_OUT:  if (item_ready || !sched_en) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid     = (state == ST_REQ);
  assign rd_req_addr      = req_addr_q;
  assign item_valid       = (state == ST_OUT) && sched_en;
  assign item_empty       = info_q.empty;
  assign item_kind        = info_q.kind;
  assign item_addr        = info_q.addr;
  assign item_unsupported = info_q.unsupported;
  assign overrun          = ovr_q;
endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
  parameter int unsigned FIDX_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sched_en,
  input logic              uframe_tick,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [31:0]       rd_req_addr,
  input logic              item_valid,
  input logic              item_ready,
  input logic              item_empty,
  input logic [1:0]        item_kind,
  input logic [31:0]       item_addr,
  input logic              item_unsupported,
  input logic              overrun,
  input logic [FIDX_W-1:0] frame_index
);
  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick |=> frame_index == $past(frame_index) + 1'b1);

  assert_req_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_single_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && item_valid));

  assert_empty_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && item_empty |-> item_addr == 32'h0 && !item_unsupported && item_kind == 2'b00);

  assert_obj_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid |-> item_addr[4:0] == 5'h0);

  assert_item_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && !item_ready |=> !sched_en || (item_valid && $stable(item_addr)
      && $stable(item_kind) && $stable(item_empty)));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_en |-> !item_valid);
endmodule

bind periodic_list_fetcher pfl_checker #(.FIDX_W(FIDX_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .sched_en         (sched_en),
  .uframe_tick      (uframe_tick),
  .rd_req_valid     (rd_req_valid),
  .rd_req_ready     (rd_req_ready),
  .rd_req_addr      (rd_req_addr),
  .item_valid       (item_valid),
  .item_ready       (item_ready),
  .item_empty       (item_empty),
  .item_kind        (item_kind),
  .item_addr        (item_addr),
  .item_unsupported (item_unsupported),
  .overrun          (overrun),
  .frame_index      (frame_index)
);

// File: tb/periodic_list_fetcher_test.sv
module periodic_list_fetcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sched_en = 1'b0;
  logic [31:0] list_base = 32'h0;
  logic [1:0]  list_len = 2'b00;
  logic        uframe_tick = 1'b0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = 32'h0;
  logic        item_valid, item_ready = 1'b0;
  logic        item_empty, item_unsupported, overrun;
  logic [1:0]  item_kind;
  logic [31:0] item_addr;
  logic [13:0] frame_index;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  periodic_list_fetcher uut (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .list_base(list_base),
    .list_len(list_len), .uframe_tick(uframe_tick),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .item_valid(item_valid), .item_ready(item_ready), .item_empty(item_empty),
    .item_kind(item_kind), .item_addr(item_addr), .item_unsupported(item_unsupported),
    .overrun(overrun), .frame_index(frame_index)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    h = (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    return {h[31:3], a[3:2], (a[11:2] % 5 == 0)};
  endfunction

  // behavioural reference: phase 0 idle, 1 request, 2 awaiting data, 3 result offered
  int          m_phase = 0;
  int          m_fidx = 0;
  logic [31:0] m_addr = 0;
  logic [31:0] m_word = 0;
  bit          m_ovr = 0;
  int          m_wcnt = 0;
  int          m_lat = 1;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_fidx = 0; m_addr = 0; m_ovr = 0; m_wcnt = 0;
    end else begin
      int len;
      len = (list_len == 2'b01) ? 512 : (list_len == 2'b10) ? 256 : 1024;
      if (uframe_tick && m_phase != 0) m_ovr = 1;
      case (m_phase)
        0: if (uframe_tick && sched_en) begin
             m_addr = {list_base[31:12], 12'h0} + ((m_fidx / 8) % len) * 4;
             m_phase = 1;
           end
        1: if (rd_req_ready) begin
             m_phase = 2; m_wcnt = 0; m_lat = 1 + int'(lfsr[9:8] % 3);
           end
        2: if (rd_rsp_valid) begin
             m_word = rd_rsp_data;
             m_phase = sched_en ? 3 : 0;
           end else m_wcnt++;
        default: if (item_ready || !sched_en) m_phase = 0;
      endcase
      if (uframe_tick) m_fidx = (m_fidx + 1) % 16384;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_iv;
      exp_iv = (m_phase == 3) && sched_en;
      chk("R2 frame_index", 32'(frame_index), 32'(m_fidx));
      chk("R5 rd_req_valid", 32'(rd_req_valid), 32'(m_phase == 1));
      if (m_phase == 1) chk("R3 R4 rd_req_addr", rd_req_addr, m_addr);
      chk(sched_en ? "R8 item_valid" : "R10 item_valid", 32'(item_valid), 32'(exp_iv));
      chk("R9 overrun", 32'(overrun), 32'(m_ovr));
      if (exp_iv) begin
        chk("R6 item_empty", 32'(item_empty), 32'(m_word[0]));
        if (m_word[0]) begin
          chk("R6 item_addr", item_addr, 32'h0);
          chk("R6 item_kind", 32'(item_kind), 32'h0);
          chk("R6 item_unsupported", 32'(item_unsupported), 32'h0);
        end else begin
          chk("R7 item_addr", item_addr, {m_word[31:5], 5'h0});
          chk("R7 item_kind", 32'(item_kind), 32'(m_word[2:1]));
          chk("R7 item_unsupported", 32'(item_unsupported), 32'(m_word[2:1] == 2'b11));
        end
      end
    end
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    rd_req_ready = !(lfsr[1:0] == 2'b00 && !rd_req_ready);
    item_ready   = !(lfsr[4:3] == 2'b00 && !item_ready);
    rd_rsp_valid = (m_phase == 2) && (m_wcnt >= m_lat);
    rd_rsp_data  = (m_phase == 2) ? mem_word(m_addr) : lfsr;
  end

  task automatic run_ticks(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 uframe_tick = 1'b1;
      @(negedge clk); #1 uframe_tick = 1'b0;
      repeat (period - 2) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    list_base = 32'h1234_5ABC;
    sched_en  = 1'b1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state at the ports
    chk("R1 frame_index", 32'(frame_index), 32'h0);
    chk("R1 rd_req_valid", 32'(rd_req_valid), 32'h0);
    chk("R1 item_valid", 32'(item_valid), 32'h0);
    chk("R1 overrun", 32'(overrun), 32'h0);
    list_len = 2'b00; run_ticks(300, 10);   // R4 full length
    list_len = 2'b10; run_ticks(2100, 10);  // R4 256-slot wrap
    list_len = 2'b01; run_ticks(2000, 10);  // R4 512-slot wrap
    list_len = 2'b00; run_ticks(4000, 10);  // R4 1024-slot wrap
    list_len = 2'b11; run_ticks(200, 10);   // R4 reserved code
    sched_en = 1'b0;  run_ticks(50, 10);    // R10 no reads while disabled
    sched_en = 1'b1;
    @(negedge clk); #1 uframe_tick = 1'b1;
    @(negedge clk); #1 uframe_tick = 1'b0;
    repeat (3) @(negedge clk); #1 sched_en = 1'b0;   // R10 drop mid-fetch
    repeat (12) @(negedge clk); #1 sched_en = 1'b1;
    list_base = 32'hFFFF_F001; list_len = 2'b10; run_ticks(100, 10);  // R3 low base bits
    run_ticks(20, 3);                       // R9 ticks closer than a fetch
    run_ticks(50, 10);                      // R9 stays set
    repeat (5) @(negedge clk);
    chk("R9 overrun sticky", 32'(overrun), 32'h1);
    finish_run();
  end
endmodule